// File: doc/BRIEF.md
# Dual-Mode Serial Control-Port Register Slave

This block is the slave side of a serial control port. It loads a small byte-wide register file over a two-wire I2C bus. The host first sends a device address, then a pointer byte that picks the target register, then any number of data bytes. The top bit of the pointer byte turns on automatic pointer stepping, so a single transaction can fill or dump a run of consecutive registers.

One device address bit comes from a strap pin. The same pin doubles as the chip select of the alternative SPI port. After reset, the first falling edge on that pin permanently hands the port over to SPI operation. From then on the I2C logic stays silent. Only the mode latch is built here; the SPI protocol itself is not part of this block.

The bus pins may run completely asynchronous to the system clock. Both bus lines and the strap are synchronised before use. The register contents are available on a flat parallel vector. Every accepted data byte also produces a one-cycle write strobe that carries its address and value.

Top module: `ctrlPortSlave`

## Requirements
- R1: The slave answers only the 7-bit address formed by the prefix 001100 followed by the current strap level (0x18 when the strap is low, 0x19 when it is high). The address is sent MSB first, and the eighth bit is read (1) or write (0). A matching address gets an ACK (SDA pulled low during the ninth clock). Any other address gets no ACK, and the slave then neither acknowledges nor stores anything until the next START.
- R2: After a matching write address, the next byte is the pointer byte, and it is acknowledged. Bits 6:0 give the register address (0 to 127). Bit 7 is the increment enable.
- R3: Every byte after the pointer byte in the same write is acknowledged and stored at the pointer address. After the ACK clock of that byte ends, wrStb is high for exactly one system clock, with wrAddr and wrData giving the pointer and the byte.
- R4: With the increment enable at 1, the pointer steps by one after each data byte written or read. From NUM_REGS-1 or any higher address, it steps to 0.
- R5: With the increment enable at 0, the pointer stays fixed, so successive data bytes overwrite the same register.
- R6: A falling edge on strapIn at any time after reset sets spiMode. spiMode then stays set until reset, and from then on sdaOe stays low and no register changes through I2C. A rising edge on strapIn has no effect on the mode.
- R7: On a matching read address, the slave drives the byte at the pointer MSB first. It starts driving SDA low only while SCL is low. It sends further bytes while the master ACKs, and releases SDA after a master NACK. Addresses at or above NUM_REGS read as 0.
- R8: Data bytes aimed at addresses at or above NUM_REGS are still acknowledged, but leave regFlat unchanged.
- R9: After reset, all registers are 0, the pointer is 0 with increment off, and sdaOe, spiMode and wrStb are low.
- R10: A repeated START in any state restarts reception at the address byte, and a STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | I2C clock as seen on the pin |
| sdaIn | input | 1 | I2C data as seen on the pin (wired-AND level) |
| strapIn | input | 1 | Address strap / SPI chip select pin |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| spiMode | output | 1 | Sticky SPI mode flag |
| wrStb | output | 1 | One-cycle write strobe per data byte |
| wrAddr | output | 7 | Pointer value of the strobed write |
| wrData | output | 8 | Byte of the strobed write |
| regFlat | output | NUM_REGS*8 | Register file contents, register n at bits 8n+7:8n |

## Verification
All 128 seven-bit addresses are offered with the strap low and again with the strap high. Only one address may be acknowledged in each sweep, which separates the fixed prefix from the strapped bit. Bursts with increment on run past the top of the file to show the wrap. Bursts with increment off and bursts to unimplemented addresses show the fixed pointer and that the stores are dropped. Reads with and without increment, including across the wrap, ended by a NACK and followed by a read with no pointer byte, show that the pointer also steps on the last byte read. Finally, a strap falling edge shows the permanent hand-over, in which a valid transaction is ignored.

// File: rtl/ctrlPortPkg.sv
package ctrlPortPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_MAP,
    ST_MAP_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } portState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMap;
    logic writeByte;
    logic advance;
  } dpCtrl_t;

  localparam logic [5:0] DEV_PREFIX = 6'b001100;

endpackage

// File: rtl/syncBit.sv
module syncBit #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cCtrl.sv
module i2cCtrl
  import ctrlPortPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapIn,
  input  logic [7:0] curByte,
  output dpCtrl_t    dpCtrl,
  output logic [7:0] rxByte,
  output logic       sdaOe,
  output logic       spiMode,
  output logic       sclLevel
);
  logic sclS, sdaS, strapS;
  logic sclP, sdaP, strapP;

  syncBit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sclSyncI (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  syncBit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sdaSyncI (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));
  syncBit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) strapSyncI (
    .clk(clk), .rstN(rstN), .d(strapIn), .q(strapS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP   <= 1'b1;
      sdaP   <= 1'b1;
      strapP <= 1'b0;
    end else begin
      sclP   <= sclS;
      sdaP   <= sdaS;
      strapP <= strapS;
    end
  end

  logic sclRise, sclFall, startEv, stopEv, strapFall;
  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startEv   = sclS & sclP & sdaP & ~sdaS;
  assign stopEv    = sclS & sclP & ~sdaP & sdaS;
  assign strapFall = strapP & ~strapS;

  // sticky mode latch
  logic spiModeR;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          spiModeR <= 1'b0;
    else if (strapFall) spiModeR <= 1'b1;
  end

  portState_t state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic [7:0] rxShift, rxN;
  logic [7:0] txShift, txN;
  logic       oeR, oeN;
  logic       ackSeen, ackN;
  dpCtrl_t    dpN;

  always_comb begin
    stateN  = state;
    bitCntN = bitCnt;
    rxN     = rxShift;
    txN     = txShift;
    oeN     = oeR;
    ackN    = ackSeen;
    dpN     = '0;
    if (spiModeR) begin
      stateN = ST_IDLE;
      oeN    = 1'b0;
    end else if (startEv) begin
      stateN  = ST_ADDR;
      bitCntN = '0;
      oeN     = 1'b0;
    end else if (stopEv) begin
      stateN = ST_IDLE;
      oeN    = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_MAP, ST_WDATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            rxN     = {rxShift[6:0], sdaS};
            bitCntN = 4'(bitCnt + 4'd1);
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN = '0;
            if (state == ST_ADDR) begin
              if (rxShift[7:1] == {DEV_PREFIX, strapS}) begin
                oeN    = 1'b1;
                stateN = ST_ADDR_ACK;
              end else begin
                stateN = ST_IGNORE;
              end
            end else if (state == ST_MAP) begin
              oeN         = 1'b1;
              dpN.loadMap = 1'b1;
              stateN      = ST_MAP_ACK;
            end else begin
              oeN    = 1'b1;
              stateN = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rxShift[0]) begin
              txN     = curByte;
              oeN     = ~curByte[7];
              bitCntN = '0;
              stateN  = ST_RDATA;
            end else begin
              oeN    = 1'b0;
              stateN = ST_MAP;
            end
          end
        end
        ST_MAP_ACK: begin
          if (sclFall) begin
            oeN    = 1'b0;
            stateN = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (sclFall) begin
            oeN           = 1'b0;
            dpN.writeByte = 1'b1;
            stateN        = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt != 4'd7) begin
              bitCntN = 4'(bitCnt + 4'd1);
              txN     = {txShift[6:0], 1'b0};
              oeN     = ~txShift[6];
            end else begin
              oeN         = 1'b0;
              dpN.advance = 1'b1;
              stateN      = ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            ackN = ~sdaS;
          end else if (sclFall) begin
            if (ackSeen) begin
              txN     = curByte;
              oeN     = ~curByte[7];
              bitCntN = '0;
              stateN  = ST_RDATA;
            end else begin
              stateN = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      oeR     <= 1'b0;
      ackSeen <= 1'b0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      rxShift <= rxN;
      txShift <= txN;
      oeR     <= oeN;
      ackSeen <= ackN;
    end
  end

  assign dpCtrl   = dpN;
  assign rxByte   = rxShift;
  assign sdaOe    = oeR;
  assign spiMode  = spiModeR;
  assign sclLevel = sclS;
endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import ctrlPortPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               dpCtrl,
  input  logic [7:0]            rxByte,
  output logic [7:0]            curByte,
  output logic                  wrStb,
  output logic [6:0]            wrAddr,
  output logic [7:0]            wrData,
  output logic [NUM_REGS*8-1:0] regFlat
);
  localparam int IDXW = $clog2(NUM_REGS);
  localparam logic [6:0] LAST_IDX = 7'(NUM_REGS - 1);

  logic [6:0] mapPtr;
  logic       incr;
  logic [6:0] nextPtr;
  logic [7:0] regs [NUM_REGS];

  assign nextPtr = (mapPtr >= LAST_IDX) ? 7'd0 : 7'(mapPtr + 7'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapPtr <= '0;
      incr   <= 1'b0;
      wrStb  <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrStb <= dpCtrl.writeByte;
      if (dpCtrl.writeByte) begin
        wrAddr <= mapPtr;
        wrData <= rxByte;
      end
      if (dpCtrl.loadMap) begin
        incr   <= rxByte[7];
        mapPtr <= rxByte[6:0];
      end else if ((dpCtrl.writeByte || dpCtrl.advance) && incr) begin
        mapPtr <= nextPtr;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[g] <= '0;
      else if (dpCtrl.writeByte && mapPtr == 7'(g)) regs[g] <= rxByte;
    end
    assign regFlat[g*8 +: 8] = regs[g];
  end

  assign curByte = (mapPtr <= LAST_IDX) ? regs[mapPtr[IDXW-1:0]] : 8'h00;
endmodule

// File: rtl/ctrlPortSlave.sv
module ctrlPortSlave
  import ctrlPortPkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic                  strapIn,
  output logic                  sdaOe,
  output logic                  spiMode,
  output logic                  wrStb,
  output logic [6:0]            wrAddr,
  output logic [7:0]            wrData,
  output logic [NUM_REGS*8-1:0] regFlat
);
  dpCtrl_t    dpCtrl;
  logic [7:0] rxByte;
  logic [7:0] curByte;
  logic       sclSync;

  i2cCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrlI (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapIn(strapIn),
    .curByte(curByte), .dpCtrl(dpCtrl), .rxByte(rxByte), .sdaOe(sdaOe),
    .spiMode(spiMode), .sclLevel(sclSync));

  regDatapath #(.NUM_REGS(NUM_REGS)) dpI (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .rxByte(rxByte),
    .curByte(curByte), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .regFlat(regFlat));
endmodule

// File: rtl/ctrlPortSlave_chk.sv
module ctrlPortSlave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sdaOe,
  input logic                  spiMode,
  input logic                  sclSync,
  input logic                  wrStb,
  input logic [6:0]            wrAddr,
  input logic [7:0]            wrData,
  input logic [NUM_REGS*8-1:0] regFlat
);
  // R6: mode latch is sticky
  p_spi_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    spiMode |=> spiMode);

  // R6: no bus drive once in SPI mode
  p_spi_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    spiMode |=> !sdaOe);

  // R7: pull-down begins only while SCL is low
  p_drive_scl_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclSync);

  // R3: strobe lasts one cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  // R3: implemented address holds the strobed byte
  p_store_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && int'(wrAddr) < NUM_REGS) |-> regFlat[int'(wrAddr)*8 +: 8] == wrData);

  // R8: unimplemented address leaves the file alone
  p_store_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && int'(wrAddr) >= NUM_REGS) |-> $stable(regFlat));
endmodule

bind ctrlPortSlave ctrlPortSlave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .spiMode(spiMode), .sclSync(sclSync),
  .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData), .regFlat(regFlat));

// File: tb/ctrlPortSlave_tb.sv
module ctrlPortSlave_tb_top;
  localparam int N    = 8;
  localparam int HALF = 12;
  localparam int QTR  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic strap = 1'b0;
  logic sdaOe, spiMode, wrStb;
  logic [6:0] wrAddr;
  logic [7:0] wrData;
  logic [N*8-1:0] regFlat;
  logic sdaLine;

  assign sdaLine = mSda & ~sdaOe;

  always #2.5 clk = ~clk;

  ctrlPortSlave #(.NUM_REGS(N)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .strapIn(strap),
    .sdaOe(sdaOe), .spiMode(spiMode), .wrStb(wrStb), .wrAddr(wrAddr),
    .wrData(wrData), .regFlat(regFlat));

  int checks = 0;
  int fails = 0;
  int wrCount = 0;
  bit done = 1'b0;
  logic [7:0] model [N];

  always @(posedge clk) if (rstN && wrStb) wrCount++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitN(HALF);
    scl = 1'b1; waitN(HALF);
    mSda = 1'b0; waitN(HALF);
    scl = 1'b0;
  endtask

  task automatic busStop();
    mSda = 1'b0; waitN(HALF);
    scl = 1'b1; waitN(HALF);
    mSda = 1'b1; waitN(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitN(HALF);
      scl = 1'b1; waitN(HALF);
      scl = 1'b0;
    end
    mSda = 1'b1; waitN(HALF);
    scl = 1'b1; waitN(QTR);
    ack = ~sdaLine;
    waitN(HALF - QTR);
    scl = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] b, input logic ackIt);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitN(HALF);
      scl = 1'b1; waitN(QTR);
      b[i] = sdaLine;
      waitN(HALF - QTR);
      scl = 1'b0;
    end
    mSda = ~ackIt; waitN(HALF);
    scl = 1'b1; waitN(HALF);
    scl = 1'b0;
    mSda = 1'b1;
  endtask

  // model of stores, computed from R2..R5, R8
  function automatic void modelWrite(input logic [7:0] mapB, input int n,
                                     input logic [7:0] base, input logic [7:0] step);
    int ptr = int'(mapB[6:0]);
    for (int i = 0; i < n; i++) begin
      if (ptr < N) model[ptr] = 8'(base + step * i);
      if (mapB[7]) ptr = (ptr >= N - 1) ? 0 : ptr + 1;
    end
  endfunction

  task automatic writeRegs(input logic [7:0] dev, input logic [7:0] mapB, input int n,
                           input logic [7:0] base, input logic [7:0] step, output int acks);
    logic a;
    acks = 0;
    busStart();
    sendByte(dev, a); acks += int'(a);
    sendByte(mapB, a); acks += int'(a);
    for (int i = 0; i < n; i++) begin
      sendByte(8'(base + step * i), a);
      acks += int'(a);
    end
    busStop();
  endtask

  task automatic checkRegs(input string req);
    int bad = 0;
    for (int g = 0; g < N; g++)
      if (regFlat[g*8 +: 8] !== model[g]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    int acks;
    int wrBefore;
    logic [7:0] rb;
    for (int g = 0; g < N; g++) model[g] = 8'h00;
    waitN(5);
    rstN = 1'b1;
    waitN(5);

    // R9: reset state
    chk("R9 sdaOe", int'(sdaOe), 0);
    chk("R9 spiMode", int'(spiMode), 0);
    chk("R9 wrStb", int'(wrStb), 0);
    checkRegs("R9 regs");

    // R1: sweep all addresses, strap low
    for (int ad = 0; ad < 128; ad++) begin
      busStart();
      sendByte(8'(ad << 1), a);
      busStop();
      chk($sformatf("R1 strap0 addr %0h", ad), int'(a), (ad == 8'h18) ? 1 : 0);
    end

    // R6: rising strap has no mode effect
    strap = 1'b1;
    waitN(10);
    chk("R6 rise ignored", int'(spiMode), 0);

    // R1: sweep all addresses, strap high
    for (int ad = 0; ad < 128; ad++) begin
      busStart();
      sendByte(8'(ad << 1), a);
      busStop();
      chk($sformatf("R1 strap1 addr %0h", ad), int'(a), (ad == 8'h19) ? 1 : 0);
    end

    // R1: mismatched address followed by bytes: no ack, no store
    wrBefore = wrCount;
    writeRegs(8'h30, 8'h80, 2, 8'hEE, 8'h01, acks);
    chk("R1 ignore after mismatch acks", acks, 0);
    chk("R1 ignore after mismatch strobes", wrCount - wrBefore, 0);
    checkRegs("R1 ignore after mismatch regs");

    // R2 R3 R4: increment burst past the top of the file
    wrBefore = wrCount;
    writeRegs(8'h32, 8'h80, N + 2, 8'h03, 8'h11, acks);
    modelWrite(8'h80, N + 2, 8'h03, 8'h11);
    chk("R2 R3 burst acks", acks, N + 4);
    chk("R3 strobe count", wrCount - wrBefore, N + 2);
    checkRegs("R4 wrap burst");

    // R5: fixed pointer overwrites one register
    writeRegs(8'h32, 8'h03, 3, 8'hA5, 8'h5B, acks);
    modelWrite(8'h03, 3, 8'hA5, 8'h5B);
    chk("R5 acks", acks, 5);
    checkRegs("R5 fixed pointer");

    // R8: unimplemented address is acked but dropped
    wrBefore = wrCount;
    writeRegs(8'h32, 8'h50, 2, 8'h77, 8'h01, acks);
    chk("R8 acks", acks, 4);
    chk("R8 strobes", wrCount - wrBefore, 2);
    checkRegs("R8 unchanged");

    // R4 R8: increment from 127 wraps to register 0
    writeRegs(8'h32, 8'hFF, 2, 8'h40, 8'h02, acks);
    modelWrite(8'hFF, 2, 8'h40, 8'h02);
    checkRegs("R4 wrap from 127");

    // R7 R10: set pointer, repeated START, read four bytes across the wrap
    busStart();
    sendByte(8'h32, a);
    sendByte(8'h86, a);
    busStart();
    sendByte(8'h33, a);
    chk("R7 read addr ack", int'(a), 1);
    for (int i = 0; i < 4; i++) begin
      readByte(rb, (i < 3) ? 1'b1 : 1'b0);
      chk($sformatf("R7 R10 read %0d", i), int'(rb), int'(model[(6 + i) % N]));
    end
    busStop();
    chk("R7 released after NACK", int'(sdaOe), 0);

    // R4: pointer stepped after the NACKed byte too
    busStart();
    sendByte(8'h33, a);
    readByte(rb, 1'b0);
    busStop();
    chk("R4 read after NACK", int'(rb), int'(model[2]));

    // R5 R7: fixed pointer read repeats the same register
    busStart();
    sendByte(8'h32, a);
    sendByte(8'h02, a);
    busStart();
    sendByte(8'h33, a);
    readByte(rb, 1'b1);
    chk("R5 read 1st", int'(rb), int'(model[2]));
    readByte(rb, 1'b0);
    chk("R5 read 2nd", int'(rb), int'(model[2]));
    busStop();

    // R7: unimplemented address reads zero
    busStart();
    sendByte(8'h32, a);
    sendByte(8'h40, a);
    busStart();
    sendByte(8'h33, a);
    readByte(rb, 1'b0);
    busStop();
    chk("R7 unimpl read", int'(rb), 0);

    // R6: strap falling edge locks SPI mode
    strap = 1'b0;
    waitN(10);
    chk("R6 spiMode set", int'(spiMode), 1);
    wrBefore = wrCount;
    writeRegs(8'h30, 8'h80, 2, 8'h99, 8'h01, acks);
    chk("R6 no ack in spi", acks, 0);
    chk("R6 no strobes", wrCount - wrBefore, 0);
    checkRegs("R6 regs unchanged");
    strap = 1'b1;
    waitN(10);
    chk("R6 stays set", int'(spiMode), 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule